// File: doc/BRIEF.md
# WEP Frame Cipher Engine

This block encrypts and decrypts the body of a wireless LAN frame, one byte at a time, with the RC4 stream cipher. For each frame it forms a cipher seed from a 24-bit initialisation vector and a secret key. The key is 40 or 104 bits long. The block then runs the RC4 key schedule over a 256-byte state array, which is single-ported. After that it combines each keystream byte with one data byte. It also computes a CRC-32 integrity value over the plaintext. On transmit, that value is appended to the frame and encrypted. On receive, it is decrypted and compared.

Key material comes from one of two places. The first is a set of four default keys, chosen by a 2-bit key index. The second is a table of per-station keys, looked up by the peer's address; a valid match in the table takes precedence over the default key. On transmit, the initialisation vector comes from a free-running pseudo-random generator. On receive, it is taken from the command. A framer upstream issues one command per frame, then streams the body through the byte ports with valid/ready handshakes.

Top module: `wep_cipher_unit`

## Requirements
- R1: After reset, `busy`, `in_ready`, `out_valid` and `icv_valid` are all low.
- R2: The seed is the IV bytes (`iv[7:0]` first), then the key bytes (`key[7:0]` first). The seed is 8 bytes long for a 40-bit key and 16 bytes for a 104-bit key. Each transmit output byte is the payload byte XOR the next RC4 keystream byte.
- R3: `in_ready` stays low for at least 1280 cycles after an accepted start command, while the state array is initialised and the key schedule runs.
- R4: On transmit, the `cmd_len` payload bytes are followed by four ICV bytes. The ICV is the ones' complement of CRC-32 over the plaintext (reflected, polynomial 0xEDB88320, initial value all ones), sent least significant byte first and encrypted with the continuing keystream. `out_last` marks only the final ICV byte.
- R5: The transmit IV is the value of a 24-bit maximal-length LFSR that steps every clock, captured at start and shown on `frame_iv`. It is never zero, and two successive frames get different IVs.
- R6: On receive, the block takes `cmd_len`+4 bytes and outputs only the `cmd_len` decrypted bytes. `out_last` marks the final one, and `frame_iv` equals `cmd_iv`.
- R7: On receive, `icv_valid` pulses for exactly one cycle, the cycle after the last ICV byte is accepted. `icv_ok` is 1 only if all four decrypted ICV bytes match the recomputed CRC.
- R8: If no station entry matches, the default key selected by `cmd_keyid` (slots 0 to 3), together with its own length flag, is used.
- R9: A valid station entry whose address equals `cmd_peer` overrides the default key. When several entries match, the entry with the lowest slot wins.
- R10: A station write with `kw_valid`=0 removes that entry from the lookup.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady, and no byte is lost.
- R12: A start command issued while `busy` is ignored. The running frame's keystream, direction and `frame_iv` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kw_en | input | 1 | Key write strobe |
| kw_station | input | 1 | 1: write station table, 0: write default key |
| kw_slot | input | SLOTW | Slot index (default keys use bits 1:0) |
| kw_valid | input | 1 | Valid bit for a station entry |
| kw_long | input | 1 | 1: 104-bit key, 0: 40-bit key |
| kw_addr | input | 48 | Station address for a table entry |
| kw_key | input | 104 | Key bytes, byte 0 in bits 7:0 |
| cmd_start | input | 1 | Start a frame |
| cmd_encrypt | input | 1 | 1: transmit (encrypt), 0: receive (decrypt) |
| cmd_keyid | input | 2 | Default key index |
| cmd_peer | input | 48 | Peer station address for table lookup |
| cmd_iv | input | 24 | Receive IV |
| cmd_len | input | LENW | Body length in bytes, ICV excluded |
| busy | output | 1 | Frame in progress |
| frame_iv | output | 24 | IV used by the current or last frame |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of the frame |
| out_ready | input | 1 | Output byte taken |
| icv_valid | output | 1 | Receive check result strobe |
| icv_ok | output | 1 | Receive check passed |

## Verification
The assertions are checked on every cycle and cover four properties:
- `in_ready` stays quiet through the key schedule window after a start;
- the output byte holds under backpressure;
- `icv_valid` is a single-cycle strobe that appears only once the block is idle;
- `frame_iv` stays stable while a frame runs.

Only the directed scenarios can show the remaining behaviour, because each needs an independent RC4 and CRC-32 model to compare against:
- that the bytes are correct;
- that the right key was selected (default, station, lowest slot, removed entry);
- that the ICV is correct or rejected.

// File: rtl/wep_pkg.sv
package wep_pkg;

    localparam int IV_W     = 24;
    localparam int KEY_W    = 104;
    localparam int ADDR_W   = 48;
    localparam int SEED_W   = 128;
    localparam int NDEF     = 4;
    localparam int SBOX_AW  = 8;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_INIT,
        ST_K0, ST_K1, ST_K2, ST_K3,
        ST_G0, ST_G1, ST_G2, ST_G3, ST_G4,
        ST_XFER, ST_EMIT
    } core_st_t;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             long_key;
    } key_sel_t;

    // One byte of reflected CRC-32, LSB first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    // Byte idx of the finished ICV (complemented register), LSB first.
    function automatic logic [7:0] icv_byte(input logic [31:0] crc, input logic [1:0] idx);
        logic [31:0] v;
        v = ~crc;
        return v[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/wep_iv_lfsr.sv
module wep_iv_lfsr
    import wep_pkg::*;
#(
    parameter logic [IV_W-1:0] SEED = 24'hACE1_35
) (
    input  logic            clk,
    input  logic            rst,
    output logic [IV_W-1:0] iv_q
);
    // Taps 24,23,22,17: maximal length, zero state unreachable from a nonzero seed.
    always_ff @(posedge clk) begin
        if (rst) begin
            iv_q <= SEED;
        end else begin
            iv_q <= {iv_q[IV_W-2:0], iv_q[23] ^ iv_q[22] ^ iv_q[21] ^ iv_q[16]};
        end
    end
endmodule

// File: rtl/wep_key_store.sv
module wep_key_store
    import wep_pkg::*;
#(
    parameter int NSTA  = 20,
    parameter int SLOTW = $clog2(NSTA)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kw_en,
    input  logic              kw_station,
    input  logic [SLOTW-1:0]  kw_slot,
    input  logic              kw_valid,
    input  logic              kw_long,
    input  logic [ADDR_W-1:0] kw_addr,
    input  logic [KEY_W-1:0]  kw_key,
    input  logic [1:0]        keyid,
    input  logic [ADDR_W-1:0] peer,
    output key_sel_t          sel
);
    logic [KEY_W-1:0]  def_key  [NDEF];
    logic [NDEF-1:0]   def_long;
    logic [KEY_W-1:0]  sta_key  [NSTA];
    logic [ADDR_W-1:0] sta_addr [NSTA];
    logic [NSTA-1:0]   sta_long;
    logic [NSTA-1:0]   sta_vld;
    logic [NSTA-1:0]   hit_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_vld  <= '0;
            def_long <= '0;
            for (int k = 0; k < NDEF; k++) def_key[k] <= '0;
        end else if (kw_en) begin
            if (kw_station) begin
                if (int'(kw_slot) < NSTA) begin
                    sta_vld[kw_slot]  <= kw_valid;
                    sta_long[kw_slot] <= kw_long;
                    sta_addr[kw_slot] <= kw_addr;
                    sta_key[kw_slot]  <= kw_key;
                end
            end else begin
                def_key[kw_slot[1:0]]  <= kw_key;
                def_long[kw_slot[1:0]] <= kw_long;
            end
        end
    end

    for (genvar g = 0; g < NSTA; g++) begin : g_cmp
        assign hit_v[g] = sta_vld[g] && (sta_addr[g] == peer);
    end

    // Lowest matching slot wins; miss falls back to the default key.
    always_comb begin
        sel.key      = def_key[keyid];
        sel.long_key = def_long[keyid];
        for (int k = NSTA - 1; k >= 0; k--) begin
            if (hit_v[k]) begin
                sel.key      = sta_key[k];
                sel.long_key = sta_long[k];
            end
        end
    end
endmodule

// File: rtl/wep_sbox_ram.sv
module wep_sbox_ram
    import wep_pkg::*;
#(
    parameter int AW = SBOX_AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end
    assign rdata = mem[addr];
endmodule

// File: rtl/wep_rc4_core.sv
module wep_rc4_core
    import wep_pkg::*;
#(
    parameter int LENW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              encrypt,
    input  logic [LENW-1:0]   len,
    input  logic              long_key,
    input  logic [SEED_W-1:0] seed,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              icv_valid,
    output logic              icv_ok,
    output logic              busy
);
    localparam int CW = LENW + 1;

    core_st_t          st_q;
    logic [7:0]        i_q, j_q, si_q, sj_q, ks_q;
    logic [CW-1:0]     cnt_q;
    logic [LENW-1:0]   len_q;
    logic              enc_q, long_q, icv_bad_q;
    logic [SEED_W-1:0] seed_q;
    logic [31:0]       crc_q;
    logic              out_valid_q, out_last_q, icv_valid_q, icv_ok_q;
    logic [7:0]        out_data_q;

    logic              ram_we;
    logic [7:0]        ram_addr, ram_wd, ram_rd;
    logic [3:0]        sidx;
    logic [7:0]        seed_b;
    logic [CW-1:0]     lenx;
    logic              icv_ph, last_ct, tx_done;
    logic [1:0]        icv_idx;
    logic [7:0]        rx_pt;
    logic              icv_hit;

    wep_sbox_ram #(.AW(SBOX_AW)) u_sbox (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wd),
        .rdata (ram_rd)
    );

    assign sidx    = long_q ? i_q[3:0] : {1'b0, i_q[2:0]};
    assign seed_b  = seed_q[{sidx, 3'b000} +: 8];
    assign lenx    = {1'b0, len_q};
    assign icv_ph  = cnt_q >= lenx;
    assign last_ct = cnt_q == lenx + CW'(3);
    assign tx_done = cnt_q == lenx + CW'(4);
    assign icv_idx = 2'(cnt_q - lenx);
    assign rx_pt   = in_data ^ ks_q;
    assign icv_hit = rx_pt == icv_byte(crc_q, icv_idx);

    // One state-array access per cycle.
    always_comb begin
        ram_we   = 1'b0;
        ram_addr = i_q;
        ram_wd   = sj_q;
        case (st_q)
            ST_INIT: begin ram_we = 1'b1; ram_addr = i_q; ram_wd = i_q; end
            ST_K0:   ram_addr = i_q;
            ST_K1:   ram_addr = j_q;
            ST_K2:   begin ram_we = 1'b1; ram_addr = i_q; ram_wd = sj_q; end
            ST_K3:   begin ram_we = 1'b1; ram_addr = j_q; ram_wd = si_q; end
            ST_G0:   ram_addr = i_q + 8'd1;
            ST_G1:   ram_addr = j_q;
            ST_G2:   begin ram_we = 1'b1; ram_addr = i_q; ram_wd = sj_q; end
            ST_G3:   begin ram_we = 1'b1; ram_addr = j_q; ram_wd = si_q; end
            ST_G4:   ram_addr = si_q + sj_q;
            default: ;
        endcase
    end

    assign in_ready  = (st_q == ST_XFER) && !(enc_q && icv_ph);
    assign busy      = st_q != ST_IDLE;
    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign out_last  = out_last_q;
    assign icv_valid = icv_valid_q;
    assign icv_ok    = icv_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            i_q         <= '0;
            j_q         <= '0;
            si_q        <= '0;
            sj_q        <= '0;
            ks_q        <= '0;
            cnt_q       <= '0;
            len_q       <= '0;
            enc_q       <= 1'b0;
            long_q      <= 1'b0;
            icv_bad_q   <= 1'b0;
            seed_q      <= '0;
            crc_q       <= CRC_INIT;
            out_valid_q <= 1'b0;
            out_last_q  <= 1'b0;
            out_data_q  <= '0;
            icv_valid_q <= 1'b0;
            icv_ok_q    <= 1'b0;
        end else begin
            icv_valid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        enc_q     <= encrypt;
                        len_q     <= len;
                        long_q    <= long_key;
                        seed_q    <= seed;
                        i_q       <= '0;
                        j_q       <= '0;
                        icv_bad_q <= 1'b0;
                        st_q      <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    i_q <= i_q + 8'd1;
                    if (i_q == 8'hFF) st_q <= ST_K0;
                end
                ST_K0: begin
                    si_q <= ram_rd;
                    j_q  <= j_q + ram_rd + seed_b;
                    st_q <= ST_K1;
                end
                ST_K1: begin
                    sj_q <= ram_rd;
                    st_q <= ST_K2;
                end
                ST_K2: st_q <= ST_K3;
                ST_K3: begin
                    i_q <= i_q + 8'd1;
                    if (i_q == 8'hFF) begin
                        j_q   <= '0;
                        cnt_q <= '0;
                        crc_q <= CRC_INIT;
                        st_q  <= ST_G0;
                    end else begin
                        st_q <= ST_K0;
                    end
                end
                ST_G0: begin
                    i_q  <= i_q + 8'd1;
                    si_q <= ram_rd;
                    j_q  <= j_q + ram_rd;
                    st_q <= ST_G1;
                end
                ST_G1: begin
                    sj_q <= ram_rd;
                    st_q <= ST_G2;
                end
                ST_G2: st_q <= ST_G3;
                ST_G3: st_q <= ST_G4;
                ST_G4: begin
                    ks_q <= ram_rd;
                    st_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (enc_q && icv_ph) begin
                        out_data_q  <= icv_byte(crc_q, icv_idx) ^ ks_q;
                        out_valid_q <= 1'b1;
                        out_last_q  <= last_ct;
                        cnt_q       <= cnt_q + CW'(1);
                        st_q        <= ST_EMIT;
                    end else if (in_valid) begin
                        cnt_q <= cnt_q + CW'(1);
                        if (enc_q) begin
                            out_data_q  <= in_data ^ ks_q;
                            out_valid_q <= 1'b1;
                            out_last_q  <= 1'b0;
                            crc_q       <= crc32_step(crc_q, in_data);
                            st_q        <= ST_EMIT;
                        end else if (!icv_ph) begin
                            out_data_q  <= rx_pt;
                            out_valid_q <= 1'b1;
                            out_last_q  <= (cnt_q + CW'(1)) == lenx;
                            crc_q       <= crc32_step(crc_q, rx_pt);
                            st_q        <= ST_EMIT;
                        end else begin
                            if (!icv_hit) icv_bad_q <= 1'b1;
                            if (last_ct) begin
                                icv_valid_q <= 1'b1;
                                icv_ok_q    <= !icv_bad_q && icv_hit;
                                st_q        <= ST_IDLE;
                            end else begin
                                st_q <= ST_G0;
                            end
                        end
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        out_valid_q <= 1'b0;
                        out_last_q  <= 1'b0;
                        st_q        <= (enc_q && tx_done) ? ST_IDLE : ST_G0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wep_cipher_unit.sv
module wep_cipher_unit
    import wep_pkg::*;
#(
    parameter int NSTA  = 20,
    parameter int LENW  = 12,
    parameter int SLOTW = $clog2(NSTA)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kw_en,
    input  logic              kw_station,
    input  logic [SLOTW-1:0]  kw_slot,
    input  logic              kw_valid,
    input  logic              kw_long,
    input  logic [47:0]       kw_addr,
    input  logic [103:0]      kw_key,
    input  logic              cmd_start,
    input  logic              cmd_encrypt,
    input  logic [1:0]        cmd_keyid,
    input  logic [47:0]       cmd_peer,
    input  logic [23:0]       cmd_iv,
    input  logic [LENW-1:0]   cmd_len,
    output logic              busy,
    output logic [23:0]       frame_iv,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              icv_valid,
    output logic              icv_ok
);
    key_sel_t          sel;
    logic [IV_W-1:0]   lfsr_iv, iv_now, frame_iv_q;
    logic              go;
    logic [SEED_W-1:0] seed;

    wep_iv_lfsr u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .iv_q (lfsr_iv)
    );

    wep_key_store #(.NSTA(NSTA), .SLOTW(SLOTW)) u_keys (
        .clk        (clk),
        .rst        (rst),
        .kw_en      (kw_en),
        .kw_station (kw_station),
        .kw_slot    (kw_slot),
        .kw_valid   (kw_valid),
        .kw_long    (kw_long),
        .kw_addr    (kw_addr),
        .kw_key     (kw_key),
        .keyid      (cmd_keyid),
        .peer       (cmd_peer),
        .sel        (sel)
    );

    assign iv_now = cmd_encrypt ? lfsr_iv : cmd_iv;
    assign seed   = {sel.key, iv_now};
    assign go     = cmd_start && !busy;

    always_ff @(posedge clk) begin
        if (rst) frame_iv_q <= '0;
        else if (go) frame_iv_q <= iv_now;
    end
    assign frame_iv = frame_iv_q;

    wep_rc4_core #(.LENW(LENW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .start     (go),
        .encrypt   (cmd_encrypt),
        .len       (cmd_len),
        .long_key  (sel.long_key),
        .seed      (seed),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready),
        .icv_valid (icv_valid),
        .icv_ok    (icv_ok),
        .busy      (busy)
    );
endmodule

// File: rtl/wep_cipher_sva.sv
module wep_cipher_sva (
    input logic        clk,
    input logic        rst,
    input logic        cmd_start,
    input logic        busy,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic        out_last,
    input logic        icv_valid,
    input logic [23:0] frame_iv
);
    localparam int SCHED_CYC = 256 * 5;   // init plus four accesses per schedule round
    localparam int SW = $clog2(SCHED_CYC + 1);

    logic [SW-1:0] sched_q;
    always_ff @(posedge clk) begin
        if (rst) sched_q <= '0;
        else if (cmd_start && !busy) sched_q <= SW'(1);
        else if (sched_q == SW'(SCHED_CYC)) sched_q <= '0;
        else if (sched_q != '0) sched_q <= sched_q + SW'(1);
    end

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_valid && !in_ready));

    p_ready_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (sched_q != '0) |-> !in_ready);

    p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_icv_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        icv_valid |=> !icv_valid);

    p_icv_end_r7: assert property (@(posedge clk) disable iff (rst)
        icv_valid |-> !busy);

    p_iv_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(frame_iv));
endmodule

bind wep_cipher_unit wep_cipher_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .busy      (busy),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .icv_valid (icv_valid),
    .frame_iv  (frame_iv)
);

// File: tb/wep_cipher_unit_tb_top.sv
module wep_cipher_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSTA  = 20;
    localparam int LENW  = 12;
    localparam int SLOTW = $clog2(NSTA);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kw_en = 0, kw_station = 0, kw_valid = 0, kw_long = 0;
    logic [SLOTW-1:0] kw_slot = '0;
    logic [47:0] kw_addr = '0;
    logic [103:0] kw_key = '0;
    logic cmd_start = 0, cmd_encrypt = 0;
    logic [1:0] cmd_keyid = '0;
    logic [47:0] cmd_peer = '0;
    logic [23:0] cmd_iv = '0;
    logic [LENW-1:0] cmd_len = '0;
    logic busy, in_ready, out_valid, out_last, icv_valid, icv_ok;
    logic [23:0] frame_iv;
    logic in_valid = 0, out_ready = 0;
    logic [7:0] in_data = '0, out_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wep_cipher_unit #(.NSTA(NSTA), .LENW(LENW)) dut_i (.*);

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] pay [0:79];
    logic [7:0] din [0:79];
    logic [7:0] got [0:79];
    logic [7:0] exp_b [0:79];
    logic [7:0] ksr [0:79];
    int got_n, last_at, last_cnt, icv_pulses;
    logic icv_seen;
    logic [23:0] fiv;

    logic [103:0] dkey [0:3];
    logic dlong [0:3];
    localparam logic [103:0] KA  = 104'h0F1E2D3C4B5A69788796A5B4C3;
    localparam logic [103:0] KB3 = 104'h00000000000000000011223344;
    localparam logic [103:0] KB12 = 104'h000000000000000000A1B2C3D4E5;
    localparam logic [47:0] PA = 48'h00_11_22_33_44_55;
    localparam logic [47:0] PB = 48'h66_77_88_99_AA_BB;
    localparam logic [47:0] PX = 48'hDE_AD_00_00_BE_EF;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (icv_valid) begin
            icv_pulses++;
            icv_seen = icv_ok;
        end
    end

    // Reference RC4 keystream from seed = IV bytes then key bytes.
    task automatic ref_ks(input logic [23:0] iv, input logic [103:0] key, input bit lng, input int n);
        logic [7:0] s [0:255];
        logic [7:0] sd [0:15];
        logic [7:0] t;
        int sl, ii, jj;
        sl = lng ? 16 : 8;
        for (int k = 0; k < 16; k++) begin
            if (k < 3) sd[k] = iv[8*k +: 8];
            else sd[k] = key[8*(k-3) +: 8];
        end
        for (int k = 0; k < 256; k++) s[k] = k[7:0];
        jj = 0;
        for (int k = 0; k < 256; k++) begin
            jj = (jj + int'(s[k]) + int'(sd[k % sl])) % 256;
            t = s[k]; s[k] = s[jj]; s[jj] = t;
        end
        ii = 0; jj = 0;
        for (int m = 0; m < n; m++) begin
            ii = (ii + 1) % 256;
            jj = (jj + int'(s[ii])) % 256;
            t = s[ii]; s[ii] = s[jj]; s[jj] = t;
            ksr[m] = s[(int'(s[ii]) + int'(s[jj])) % 256];
        end
    endtask

    function automatic logic [31:0] ref_icv(input int n);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < n; k++) begin
            c = c ^ {24'h0, pay[k]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic prog(input bit st, input int slot, input bit vld, input bit lng,
                        input logic [47:0] addr, input logic [103:0] key);
        @(negedge clk);
        kw_en = 1; kw_station = st; kw_slot = SLOTW'(slot); kw_valid = vld;
        kw_long = lng; kw_addr = addr; kw_key = key;
        @(negedge clk);
        kw_en = 0;
    endtask

    task automatic fill_pay(input int n, input int salt);
        for (int k = 0; k < n; k++) pay[k] = 8'((k * 37 + salt * 11 + 5) & 255);
    endtask

    task automatic run_frame(input bit enc, input logic [1:0] kid, input logic [47:0] peer,
                             input logic [23:0] iv, input int len, input bit bp,
                             input bit inject, input string rq3);
        int nin, nout, rdy_hi;
        nin  = enc ? len : len + 4;
        nout = enc ? len + 4 : len;
        got_n = 0; last_at = -1; last_cnt = 0; icv_pulses = 0;
        @(negedge clk);
        cmd_start = 1; cmd_encrypt = enc; cmd_keyid = kid; cmd_peer = peer;
        cmd_iv = iv; cmd_len = LENW'(len);
        @(negedge clk);
        cmd_start = 0;
        fiv = frame_iv;
        rdy_hi = 0;
        for (int c = 0; c < 1280; c++) begin
            if (in_ready) rdy_hi++;
            @(negedge clk);
        end
        check(rdy_hi == 0, rq3, rdy_hi, 0);
        fork
            begin
                int k = 0;
                while (k < nin) begin
                    in_valid = 1; in_data = din[k];
                    if (in_ready) k++;
                    @(negedge clk);
                end
                in_valid = 0;
            end
            begin
                int cyc = 0;
                bit rdy;
                while (got_n < nout) begin
                    rdy = bp ? ((cyc % 3) != 0) : 1'b1;
                    out_ready = rdy;
                    if (out_valid && rdy) begin
                        got[got_n] = out_data;
                        if (out_last) begin last_at = got_n; last_cnt++; end
                        got_n++;
                    end
                    cyc++;
                    @(negedge clk);
                end
                out_ready = 1;
            end
            begin
                if (inject) begin
                    repeat (12) @(negedge clk);
                    cmd_start = 1; cmd_encrypt = ~enc; cmd_keyid = ~kid; cmd_iv = ~iv;
                    @(negedge clk);
                    cmd_start = 0;
                end
            end
        join
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic tx_expect(input logic [103:0] key, input bit lng, input int n);
        logic [31:0] icv;
        ref_ks(fiv, key, lng, n + 4);
        icv = ref_icv(n);
        for (int k = 0; k < n; k++) exp_b[k] = pay[k] ^ ksr[k];
        for (int b = 0; b < 4; b++) exp_b[n + b] = icv[8*b +: 8] ^ ksr[n + b];
    endtask

    task automatic cmp_bytes(input int n, input string rq);
        int bad;
        bad = 0;
        check(got_n == n, {rq, " count"}, got_n, n);
        for (int k = 0; k < n; k++) begin
            if (got[k] !== exp_b[k]) begin
                bad++;
                check(0, rq, got[k], exp_b[k]);
            end
        end
        if (bad == 0) check(1, rq, 0, 0);
    endtask

    task automatic t_reset();
        check(!busy && !in_ready, "R1 busy/in_ready", {busy, in_ready}, 0);
        check(!out_valid && !icv_valid, "R1 out_valid/icv_valid", {out_valid, icv_valid}, 0);
    endtask

    task automatic t_tx_def40();
        fill_pay(8, 1);
        for (int k = 0; k < 8; k++) din[k] = pay[k];
        run_frame(1, 2'd1, PX, 24'h0, 8, 0, 0, "R3");
        tx_expect(dkey[1], dlong[1], 8);
        cmp_bytes(12, "R2 R8 tx 40-bit default");
        check(last_at == 11 && last_cnt == 1, "R4 out_last", last_at, 11);
    endtask

    logic [23:0] iv_a, iv_b;

    task automatic t_tx_def104_bp();
        iv_a = fiv;
        fill_pay(12, 2);
        for (int k = 0; k < 12; k++) din[k] = pay[k];
        run_frame(1, 2'd3, PX, 24'h0, 12, 1, 0, "R3");
        iv_b = fiv;
        tx_expect(dkey[3], dlong[3], 12);
        cmp_bytes(16, "R11 R4 tx 104-bit backpressure");
    endtask

    task automatic t_iv();
        check(iv_a != 24'h0 && iv_b != 24'h0, "R5 iv nonzero", iv_b, 1);
        check(iv_a != iv_b, "R5 iv differs", iv_b, iv_a);
    endtask

    task automatic t_tx_station(input logic [47:0] peer, input logic [103:0] key,
                                input bit lng, input string rq);
        fill_pay(6, 3);
        for (int k = 0; k < 6; k++) din[k] = pay[k];
        run_frame(1, 2'd0, peer, 24'h0, 6, 0, 0, "R3");
        tx_expect(key, lng, 6);
        cmp_bytes(10, rq);
    endtask

    task automatic t_rx(input bit corrupt);
        logic [31:0] icv;
        logic [23:0] riv;
        riv = 24'h563412;
        fill_pay(10, 4);
        ref_ks(riv, dkey[2], dlong[2], 14);
        icv = ref_icv(10);
        for (int k = 0; k < 10; k++) din[k] = pay[k] ^ ksr[k];
        for (int b = 0; b < 4; b++) din[10 + b] = icv[8*b +: 8] ^ ksr[10 + b];
        if (corrupt) din[12] = din[12] ^ 8'h10;
        for (int k = 0; k < 10; k++) exp_b[k] = pay[k];
        run_frame(0, 2'd2, PX, riv, 10, 0, 0, "R3");
        check(fiv == riv, "R6 frame_iv", fiv, riv);
        cmp_bytes(10, "R6 rx plaintext");
        check(last_at == 9, "R6 out_last", last_at, 9);
        check(icv_pulses == 1, "R7 icv_valid pulse", icv_pulses, 1);
        check(icv_seen == !corrupt, "R7 icv_ok", icv_seen, !corrupt);
    endtask

    task automatic t_busy_start();
        logic [23:0] f0;
        fill_pay(16, 5);
        for (int k = 0; k < 16; k++) din[k] = pay[k];
        run_frame(1, 2'd1, PX, 24'h0, 16, 0, 1, "R3");
        f0 = fiv;
        check(frame_iv == f0, "R12 frame_iv held", frame_iv, f0);
        tx_expect(dkey[1], dlong[1], 16);
        cmp_bytes(20, "R12 start while busy ignored");
        check(!busy, "R12 no second frame", busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        dkey[0] = 104'h0000000000000000000102030405; dlong[0] = 0;
        dkey[1] = 104'h000000000000000000C0FFEE1234; dlong[1] = 0;
        dkey[2] = 104'h1122334455667788990AABBCCD;   dlong[2] = 1;
        dkey[3] = 104'hF0E1D2C3B4A5968778695A4B3C;   dlong[3] = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        for (int k = 0; k < 4; k++) prog(0, k, 1, dlong[k], 48'h0, dkey[k]);
        prog(1, 5, 1, 1, PA, KA);
        prog(1, 12, 1, 0, PB, KB12);
        prog(1, 3, 1, 0, PB, KB3);
        t_tx_def40();
        t_tx_def104_bp();
        t_iv();
        t_tx_station(PA, KA, 1, "R9 station override");
        t_tx_station(PB, KB3, 0, "R9 lowest slot wins");
        t_rx(0);
        t_rx(1);
        prog(1, 3, 0, 0, PB, KB3);
        t_tx_station(PB, KB12, 0, "R10 removed entry skipped");
        prog(1, 12, 0, 0, PB, KB12);
        t_tx_station(PB, dkey[0], dlong[0], "R10 R8 fallback to default");
        t_busy_start();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule